// File: doc/BRIEF.md
# Quarter-Wave Sine Synthesizer Datapath

This block is the core of a direct digital frequency synthesizer. Each enabled clock it adds a frequency control word to a wide phase accumulator. It keeps only the top bits of that accumulator as the phase and turns the phase into a signed sine sample. The output frequency is `fcw * f_clk / 2^ACC_W`.

Only one quarter of the wave is stored, in a table built at elaboration. The two top phase bits pick the quadrant. The second-highest bit reflects the table address by inverting every address bit. The top bit negates the looked-up magnitude.

The table is sampled half a phase step off the grid, so the reflection needs no plus-or-minus-one correction. The peak amplitude is the largest positive code plus a small signed sub-amplitude. That sub-amplitude is a parameter in units of 1/10000 LSB and lets the integrator trim the rounding pattern of the table.

Top module: `qsine_ddfs`

## Requirements
- R1: While `rst` is high at a rising edge, `sample` becomes 0 and `valid` becomes 0. The accumulator clears as well, so the first valid sample after reset is table entry 0 with a positive sign.
- R2: On every rising edge with `en` high and `rst` low, the accumulator becomes `(acc + fcw) mod 2^ACC_W`.
- R3: The phase is bits `[ACC_W-1 : ACC_W-PH_W]` of the accumulator. The lower `ACC_W-PH_W` bits never affect the sample.
- R4: Table entry i, for i from 0 to `2^(PH_W-2)-1`, holds `round(A * sin((i+0.5) * pi / 2^(PH_W-1)))`, with `A = 2^(OUT_W-1) - 1 + SUB_AMP_E4/10000`.
- R5: When phase bit `PH_W-2` is 1, the table address is the bitwise inverse of the low `PH_W-2` phase bits. Otherwise the address is those bits unchanged.
- R6: When phase bit `PH_W-1` is 1, `sample` is the two's-complement negation of the table value. Otherwise it is the table value.
- R7: The sample for a given accumulator value appears on `sample` after two further enabled edges. `valid` rises on the second enabled edge after reset and then stays high until the next reset.
- R8: On an edge with `en` low and `rst` low, `sample` and `valid` keep their values.
- R9: The magnitude never exceeds `2^(OUT_W-1)-1`. For every phase p, the sample at `p + 2^(PH_W-1)` equals the negation of the sample at p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the accumulator and the pipeline |
| fcw | input | ACC_W | Frequency control word |
| sample | output | OUT_W | Signed sine sample, two's complement |
| valid | output | 1 | Sample holds real data |

## Verification
A sample is due exactly two enabled edges after the accumulator holds its phase. Edges with `en` low do not count toward that distance.

The bench keeps its own count of enabled edges since reset and samples one nanosecond after each rising edge. From that count it derives the accumulator value behind the current output. It then evaluates the sine directly over the full wave, with no reflection and no table, and compares the result.

Idle edges leave the count unchanged, so the same expected value also checks that the output holds.

// File: rtl/qsine_ddfs.sv
module qsine_ddfs #(
  parameter int ACC_W      = 24,
  parameter int PH_W       = 12,
  parameter int OUT_W      = 7,
  parameter int SUB_AMP_E4 = 2423
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        fcw,
  output logic signed [OUT_W-1:0] sample,
  output logic                    valid
);
  localparam int  ADDR_W  = PH_W - 2;
  localparam int  DEPTH   = 1 << ADDR_W;
  localparam int  MAG_W   = OUT_W - 1;
  localparam int  MAG_MAX = (1 << MAG_W) - 1;
  localparam real PI      = 3.14159265358979323846;

  function automatic real taylor_sin(real x);
    real term = x;
    real sum  = x;
    for (int k = 1; k < 14; k++) begin
      term = -term * x * x / ((2.0 * k) * (2.0 * k + 1.0));
      sum  = sum + term;
    end
    return sum;
  endfunction

  function automatic logic [DEPTH*MAG_W-1:0] build_table();
    logic [DEPTH*MAG_W-1:0] t = '0;
    real amp = real'(MAG_MAX) + real'(SUB_AMP_E4) / 10000.0;
    for (int i = 0; i < DEPTH; i++) begin
      real v = amp * taylor_sin((real'(i) + 0.5) * PI / real'(1 << (PH_W - 1)));
      int  r = $rtoi(v + 0.5);
      if (r > MAG_MAX) r = MAG_MAX;
      if (r < 0) r = 0;
      t[i*MAG_W +: MAG_W] = r[MAG_W-1:0];
    end
    return t;
  endfunction

  localparam logic [DEPTH*MAG_W-1:0] LUT = build_table();

  logic [ACC_W-1:0] acc;
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic             pre_vld;

  wire [PH_W-1:0]   phase = acc[ACC_W-1 -: PH_W];
  wire [ADDR_W-1:0] addr  = phase[PH_W-2] ? ~phase[ADDR_W-1:0] : phase[ADDR_W-1:0];
  wire signed [OUT_W-1:0] mag_ext = {1'b0, mag_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      mag_q   <= '0;
      neg_q   <= 1'b0;
      pre_vld <= 1'b0;
      sample  <= '0;
      valid   <= 1'b0;
    end else if (en) begin
      acc     <= acc + fcw;
      mag_q   <= LUT[int'(addr)*MAG_W +: MAG_W];
      neg_q   <= phase[PH_W-1];
      pre_vld <= 1'b1;
      sample  <= neg_q ? -mag_ext : mag_ext;
      valid   <= pre_vld;
    end
  end
endmodule

// File: rtl/qsine_ddfs_chk.sv
module qsine_ddfs_chk #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        fcw,
  input logic [ACC_W-1:0]        acc,
  input logic signed [OUT_W-1:0] sample,
  input logic                    valid
);
  localparam int MAG_MAX = (1 << (OUT_W - 1)) - 1;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!valid && sample == '0)); // R1
  AST_FIRST_POSITIVE: assert property (@(posedge clk) disable iff (rst) $rose(valid) |-> !sample[OUT_W-1]); // R1
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst) en |=> acc == $past(acc + fcw)); // R2
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst) valid |=> valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> ($stable(sample) && $stable(valid))); // R8
  AST_MAG_BOUND: assert property (@(posedge clk) disable iff (rst) (int'(sample) >= -MAG_MAX && int'(sample) <= MAG_MAX)); // R9
endmodule

bind qsine_ddfs qsine_ddfs_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .fcw(fcw), .acc(acc), .sample(sample), .valid(valid)
);

// File: tb/sim_qsine_ddfs.sv
`timescale 1ns/1ps
module sim_qsine_ddfs;
  localparam int L = 10, W = 6, D = 5, SUB = 2423;
  localparam int HALF = 1 << (W - 1);

  logic clk = 0, rst = 1, en = 0;
  logic [L-1:0] fcw = '0;
  logic signed [D-1:0] sample;
  logic valid;
  int vectors = 0, errors = 0;
  int obs [1<<W];

  qsine_ddfs #(.ACC_W(L), .PH_W(W), .OUT_W(D), .SUB_AMP_E4(SUB)) u0 (
    .clk(clk), .rst(rst), .en(en), .fcw(fcw), .sample(sample), .valid(valid));

  always #2.5 clk = ~clk;

  function automatic int ref_sample(int ph);
    real amp = real'((1 << (D - 1)) - 1) + real'(SUB) / 10000.0;
    real v = amp * $sin((real'(ph) + 0.5) * 2.0 * 3.14159265358979323846 / real'(1 << W));
    int m = $rtoi((v < 0.0 ? -v : v) + 0.5);
    return (v < 0.0) ? -m : m;
  endfunction

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run(int f, int en_pct, int n, string tag, bit record);
    int n_en = 0;
    rst = 1; en = 0; fcw = '0;
    tick(); tick();
    check("R1 sample in reset", int'(sample), 0);
    check("R1 valid in reset", int'(valid), 0);
    rst = 0; fcw = L'(f);
    for (int c = 0; c < n; c++) begin
      bit e = ($urandom % 100) < en_pct;
      en = e;
      tick();
      if (e) n_en++;
      check({tag, (e ? "" : " R8 idle"), " R7 valid"}, int'(valid), int'(n_en >= 2));
      if (n_en >= 2) begin
        int a  = int'((longint'(n_en - 2) * f) % (1 << L));
        int ph = a >> (L - W);
        string t = (n_en == 2) ? "R1 first" : (ph >= HALF ? "R6 sign" : (ph[W-2] ? "R5 mirror" : "R4 table"));
        check({tag, " ", t, (e ? "" : " R8 idle")}, int'(sample), ref_sample(ph));
        if (record) obs[ph] = int'(sample);
      end
    end
    en = 0;
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R3: fcw 1 steps the phase once every 2^(L-W) samples
    run(1, 100, (1 << L) + 2, "R2 R3 fcw1", 1);
    for (int p = 0; p < HALF; p++)
      check("R9 symmetry", obs[p + HALF], -obs[p]);
    begin
      int mx = 0;
      for (int p = 0; p < (1 << W); p++) if (obs[p] > mx) mx = obs[p];
      check("R9 peak", mx, (1 << (D - 1)) - 1);
    end
    run(1 + 2 * ($urandom % 500), 70, (1 << L) + 40, "R2 odd random en", 0);
    run(0, 100, 40, "R2 fcw0", 0);
    run(1 << (L - 1), 100, 40, "R6 half turn", 0);
    run((1 << L) - 1, 90, 300, "R2 wrap backward", 0);
    run(7, 100, 300, "R3 small step", 0);
    run(1 << (L - W), 50, 200, "R3 one phase step", 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule